// File: doc/BRIEF.md
# Interrupt Controller Mode Lock Gate

This block sits between software-visible access paths and the register file of a local interrupt controller. It holds the controller's base/mode register and enforces a configuration-time lock on the register-mapped (extended) operating mode. Once the lock input is high and the controller is in extended mode, software cannot leave that mode or disable the controller through the base register. Legacy memory-mapped accesses are also no longer decoded.

Indexed register-port accesses write the base register and read it back. They also read a capability register and a read-only lock status register. Memory-mapped accesses normally pass straight through to the register file. When the gate blocks them, reads return all ones, writes are discarded, and a machine-check request carrying the physical address can optionally be raised. Illegal register-port writes produce a general-protection fault pulse.

Top module: `icmode_lock_gate`

## Requirements
- R1: With `cfg_lock` high and base bit 10 (extended) set, a base-register write whose data clears bit 10 or bit 11 (enable) pulses `gp_fault`, and the base register keeps its old value.
- R2: A base-register write is accepted without a fault when `cfg_lock` is low, when base bit 10 is currently clear, or when the written data has both bit 10 and bit 11 set.
- R3: With `cfg_lock` high and base bits 11 and 10 both set (extended mode), a memory-mapped read does not assert `rf_rd`, and `mm_rdata` is 0xFFFFFFFF in the same cycle.
- R4: In the locked extended mode of R3, a memory-mapped write does not assert `rf_wr`.
- R5: A blocked memory-mapped access pulses `mc_req` only when `cfg_mce_en` is high. `mc_addr` is then 0xFEE00000 ORed with the 12-bit offset, and `mc_status` is 4'b1111 ({valid, uncorrected, enabled, address-valid}).
- R6: When access is not blocked, `rf_rd`/`rf_wr`/`rf_wdata` follow the memory-mapped strobes and data, `rf_idx` is `mm_off[11:4]`, and `mm_rdata` equals `rf_rdata`.
- R7: A read of register index 0x0BD returns bit 0 = 1 exactly when `cfg_lock` is high and the controller is in extended mode; all other bits are zero.
- R8: Any write to index 0x0BD pulses `gp_fault`.
- R9: A read of index 0x10A returns 64'h0000_0000_0C00_0001, with bit 21 also set whenever `cfg_lock` is high.
- R10: After reset, reading index 0x01B returns 0xFEE00800: enable (bit 11) set and extended (bit 10) clear.
- R11: `gp_fault`, `mc_req` and `msr_rdata` are registered. They change on the first rising edge after the strobe, and a pulse lasts one cycle for a one-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lock | input | 1 | Static lock of extended mode |
| cfg_mce_en | input | 1 | Static enable for machine-check requests |
| msr_wr_en | input | 1 | Indexed register write strobe |
| msr_rd_en | input | 1 | Indexed register read strobe |
| msr_idx | input | 12 | Indexed register number |
| msr_wdata | input | 64 | Indexed register write data |
| msr_rdata | output | 64 | Indexed register read data, valid the cycle after the strobe |
| gp_fault | output | 1 | General-protection fault pulse |
| mm_rd | input | 1 | Memory-mapped read strobe |
| mm_wr | input | 1 | Memory-mapped write strobe |
| mm_off | input | 12 | Memory-mapped byte offset |
| mm_wdata | input | 32 | Memory-mapped write data |
| mm_rdata | output | 32 | Memory-mapped read data (same cycle) |
| rf_rd | output | 1 | Register file read strobe |
| rf_wr | output | 1 | Register file write strobe |
| rf_idx | output | 8 | Register file slot index |
| rf_wdata | output | 32 | Register file write data |
| rf_rdata | input | 32 | Register file read data |
| mc_req | output | 1 | Machine-check request pulse |
| mc_addr | output | 32 | Faulting physical address |
| mc_status | output | 4 | Machine-check status flags |

## Verification
A corrupted base register shows up at once in three places. The blocking decision on the very next memory-mapped strobe changes, bit 0 of the status register read back one cycle later changes, and the base readback itself differs. A lost lock term lets a mode-exit write through, which shows as a missing `gp_fault` one cycle after the strobe and as a changed readback on the next read. A stuck fault or request register shows as a pulse that lasts past its single cycle.

// File: rtl/lkg_pkg.sv
package lkg_pkg;
  localparam int MSR_DW     = 64;
  localparam int IDX_W      = 12;
  localparam int MM_DW      = 32;
  localparam int OFF_W      = 12;
  localparam int SLOT_LSB   = 4;
  localparam int BIT_EN     = 11;
  localparam int BIT_EXT    = 10;
  localparam int CAP_LOCK_B = 21;
  localparam int MC_FLAGS_W = 4;
  localparam logic [MM_DW-1:0]  DEF_BASE = 32'hFEE0_0000;
  localparam logic [MSR_DW-1:0] RST_BASE = 64'h0000_0000_FEE0_0800;
  localparam logic [MSR_DW-1:0] CAP_DEF  = 64'h0000_0000_0C00_0001;
endpackage

// File: rtl/lkg_base_ctl.sv
module lkg_base_ctl
  import lkg_pkg::*;
#(
  parameter int                DW       = MSR_DW,
  parameter int                IW       = IDX_W,
  parameter logic [IW-1:0]     BASE_IDX = 12'h01B,
  parameter logic [IW-1:0]     CAP_IDX  = 12'h10A,
  parameter logic [IW-1:0]     STAT_IDX = 12'h0BD,
  parameter logic [DW-1:0]     CAP_BASE = CAP_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_lock,
  input  logic          msr_wr_en,
  input  logic          msr_rd_en,
  input  logic [IW-1:0] msr_idx,
  input  logic [DW-1:0] msr_wdata,
  output logic [DW-1:0] msr_rdata,
  output logic          gp_fault,
  output logic          xmode
);
  logic [DW-1:0] base_q, base_d, rdata_q, rdata_d;
  logic          gp_q, gp_d;
  logic          hit_base, hit_cap, hit_stat, exits_mode, base_we;

  always_comb begin
    hit_base   = (msr_idx == BASE_IDX);
    hit_cap    = (msr_idx == CAP_IDX);
    hit_stat   = (msr_idx == STAT_IDX);
    exits_mode = cfg_lock & base_q[BIT_EXT] &
                 (~msr_wdata[BIT_EXT] | ~msr_wdata[BIT_EN]);
    base_we    = msr_wr_en & hit_base & ~exits_mode;
    base_d     = base_we ? msr_wdata : base_q;
    gp_d       = msr_wr_en & ((hit_base & exits_mode) | hit_stat);
    rdata_d    = '0;
    if (hit_base) begin
      rdata_d = base_q;
    end else if (hit_cap) begin
      rdata_d = CAP_BASE;
      rdata_d[CAP_LOCK_B] = CAP_BASE[CAP_LOCK_B] | cfg_lock;
    end else if (hit_stat) begin
      rdata_d[0] = cfg_lock & xmode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= RST_BASE;
      rdata_q <= '0;
      gp_q    <= 1'b0;
    end else begin
      base_q <= base_d;
      gp_q   <= gp_d;
      if (msr_rd_en) rdata_q <= rdata_d;
    end
  end

  assign xmode     = base_q[BIT_EN] & base_q[BIT_EXT];
  assign msr_rdata = rdata_q;
  assign gp_fault  = gp_q;

  p_ext_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lock && base_q[BIT_EXT]) |=> base_q[BIT_EXT]);
  p_fault_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> $past(msr_wr_en));
  p_base_only_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !msr_wr_en |=> $stable(base_q));
endmodule

// File: rtl/lkg_mmio_gate.sv
module lkg_mmio_gate
  import lkg_pkg::*;
#(
  parameter int             DW      = MM_DW,
  parameter int             OW      = OFF_W,
  parameter int             LSB     = SLOT_LSB,
  parameter int             FW      = MC_FLAGS_W,
  parameter logic [DW-1:0]  MC_BASE = DEF_BASE,
  localparam int            RIW     = OW - LSB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_lock,
  input  logic           cfg_mce_en,
  input  logic           xmode,
  input  logic           mm_rd,
  input  logic           mm_wr,
  input  logic [OW-1:0]  mm_off,
  input  logic [DW-1:0]  mm_wdata,
  output logic [DW-1:0]  mm_rdata,
  output logic           rf_rd,
  output logic           rf_wr,
  output logic [RIW-1:0] rf_idx,
  output logic [DW-1:0]  rf_wdata,
  input  logic [DW-1:0]  rf_rdata,
  output logic           mc_req,
  output logic [DW-1:0]  mc_addr,
  output logic [FW-1:0]  mc_status
);
  logic          blocked, mc_d, mc_q;
  logic [DW-1:0] addr_d, addr_q;

  always_comb begin
    blocked  = cfg_lock & xmode;
    rf_rd    = mm_rd & ~blocked;
    rf_wr    = mm_wr & ~blocked;
    rf_idx   = mm_off[OW-1:LSB];
    rf_wdata = mm_wdata;
    mm_rdata = blocked ? '1 : rf_rdata;
    mc_d     = blocked & (mm_rd | mm_wr) & cfg_mce_en;
    addr_d   = MC_BASE | DW'(mm_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      mc_q <= mc_d;
      if (mc_d) addr_q <= addr_d;
    end
  end

  assign mc_req    = mc_q;
  assign mc_addr   = addr_q;
  assign mc_status = '1;

  p_no_rf_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lock && xmode && mm_rd) |-> (!rf_rd && mm_rdata == '1));
  p_no_rf_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lock && xmode) |-> !rf_wr);
  p_mc_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mc_req |-> ($past(cfg_mce_en) && $past(mm_rd || mm_wr)));
endmodule

// File: rtl/icmode_lock_gate.sv
module icmode_lock_gate
  import lkg_pkg::*;
#(
  parameter int               MDW      = MSR_DW,
  parameter int               IW       = IDX_W,
  parameter int               DW       = MM_DW,
  parameter int               OW       = OFF_W,
  parameter int               FW       = MC_FLAGS_W,
  parameter logic [IW-1:0]    BASE_IDX = 12'h01B,
  parameter logic [IW-1:0]    CAP_IDX  = 12'h10A,
  parameter logic [IW-1:0]    STAT_IDX = 12'h0BD,
  localparam int              RIW      = OW - SLOT_LSB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_lock,
  input  logic           cfg_mce_en,
  input  logic           msr_wr_en,
  input  logic           msr_rd_en,
  input  logic [IW-1:0]  msr_idx,
  input  logic [MDW-1:0] msr_wdata,
  output logic [MDW-1:0] msr_rdata,
  output logic           gp_fault,
  input  logic           mm_rd,
  input  logic           mm_wr,
  input  logic [OW-1:0]  mm_off,
  input  logic [DW-1:0]  mm_wdata,
  output logic [DW-1:0]  mm_rdata,
  output logic           rf_rd,
  output logic           rf_wr,
  output logic [RIW-1:0] rf_idx,
  output logic [DW-1:0]  rf_wdata,
  input  logic [DW-1:0]  rf_rdata,
  output logic           mc_req,
  output logic [DW-1:0]  mc_addr,
  output logic [FW-1:0]  mc_status
);
  logic xmode;

  lkg_base_ctl #(
    .DW(MDW), .IW(IW), .BASE_IDX(BASE_IDX), .CAP_IDX(CAP_IDX),
    .STAT_IDX(STAT_IDX), .CAP_BASE(CAP_DEF)
  ) u_base (
    .clk(clk), .rst_n(rst_n), .cfg_lock(cfg_lock),
    .msr_wr_en(msr_wr_en), .msr_rd_en(msr_rd_en), .msr_idx(msr_idx),
    .msr_wdata(msr_wdata), .msr_rdata(msr_rdata), .gp_fault(gp_fault),
    .xmode(xmode)
  );

  lkg_mmio_gate #(
    .DW(DW), .OW(OW), .LSB(SLOT_LSB), .FW(FW), .MC_BASE(DEF_BASE)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .cfg_lock(cfg_lock), .cfg_mce_en(cfg_mce_en),
    .xmode(xmode), .mm_rd(mm_rd), .mm_wr(mm_wr), .mm_off(mm_off),
    .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .rf_rd(rf_rd), .rf_wr(rf_wr),
    .rf_idx(rf_idx), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .mc_req(mc_req), .mc_addr(mc_addr), .mc_status(mc_status)
  );

  p_pulses_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_wr_en && !mm_rd && !mm_wr) |=> (!gp_fault && !mc_req));
endmodule

// File: tb/test_icmode_lock_gate.sv
`timescale 1ns/1ps
module test_icmode_lock_gate;
  localparam logic [11:0] IX_BASE = 12'h01B;
  localparam logic [11:0] IX_CAP  = 12'h10A;
  localparam logic [11:0] IX_STAT = 12'h0BD;
  localparam logic [63:0] CAPV    = 64'h0000_0000_0C00_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_lock = 1'b0, cfg_mce_en = 1'b0;
  logic msr_wr_en = 1'b0, msr_rd_en = 1'b0;
  logic [11:0] msr_idx = '0;
  logic [63:0] msr_wdata = '0, msr_rdata;
  logic gp_fault;
  logic mm_rd = 1'b0, mm_wr = 1'b0;
  logic [11:0] mm_off = '0;
  logic [31:0] mm_wdata = '0, mm_rdata, rf_wdata, rf_rdata, mc_addr;
  logic rf_rd, rf_wr, mc_req;
  logic [7:0] rf_idx;
  logic [3:0] mc_status;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;
  assign rf_rdata = {24'hA5A5A5, rf_idx};

  icmode_lock_gate i_icmode_lock_gate (
    .clk(clk), .rst_n(rst_n), .cfg_lock(cfg_lock), .cfg_mce_en(cfg_mce_en),
    .msr_wr_en(msr_wr_en), .msr_rd_en(msr_rd_en), .msr_idx(msr_idx),
    .msr_wdata(msr_wdata), .msr_rdata(msr_rdata), .gp_fault(gp_fault),
    .mm_rd(mm_rd), .mm_wr(mm_wr), .mm_off(mm_off), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_idx(rf_idx),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .mc_req(mc_req),
    .mc_addr(mc_addr), .mc_status(mc_status)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write, returns gp_fault seen after the edge
  task automatic msr_wr(input logic [11:0] idx, input logic [63:0] d, output logic gp);
    @(negedge clk);
    msr_idx = idx; msr_wdata = d; msr_wr_en = 1'b1;
    @(negedge clk);
    gp = gp_fault; msr_wr_en = 1'b0;
  endtask

  task automatic msr_rd(input logic [11:0] idx, output logic [63:0] d);
    @(negedge clk);
    msr_idx = idx; msr_rd_en = 1'b1;
    @(negedge clk);
    d = msr_rdata; msr_rd_en = 1'b0;
  endtask

  task automatic mm_acc(input logic rd, input logic wr, input logic [11:0] off,
                        output logic [31:0] rdat, output logic s_rd, output logic s_wr,
                        output logic [7:0] s_idx, output logic mc, output logic [31:0] maddr);
    @(negedge clk);
    mm_rd = rd; mm_wr = wr; mm_off = off; mm_wdata = 32'hC0DE_0000 | 32'(off);
    #1;
    rdat = mm_rdata; s_rd = rf_rd; s_wr = rf_wr; s_idx = rf_idx;
    @(negedge clk);
    mc = mc_req; maddr = mc_addr; mm_rd = 1'b0; mm_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R11 gp idle after reset", 64'(gp_fault), 0);
    check("R11 mc idle after reset", 64'(mc_req), 0);
    msr_rd(IX_BASE, d);
    check("R10 base reset value", d, 64'hFEE0_0800);
  endtask

  task automatic t_unlocked;
    logic g; logic [63:0] d; logic [31:0] rd, ma; logic srd, swr, mc; logic [7:0] si;
    cfg_lock = 1'b0;
    msr_wr(IX_BASE, 64'hFEE0_0C00, g);
    check("R2 unlocked enter ext no fault", 64'(g), 0);
    mm_acc(1'b1, 1'b0, 12'h320, rd, srd, swr, si, mc, ma);
    check("R6 pass read strobe", 64'(srd), 1);
    check("R6 slot index", 64'(si), 64'h32);
    check("R6 read data", 64'(rd), 64'hA5A5_A532);
    mm_acc(1'b0, 1'b1, 12'h0F0, rd, srd, swr, si, mc, ma);
    check("R6 pass write strobe", 64'(swr), 1);
    msr_rd(IX_STAT, d);
    check("R7 status unlocked", d, 0);
    msr_rd(IX_CAP, d);
    check("R9 cap unlocked", d, CAPV);
  endtask

  task automatic t_lock_reject;
    logic g; logic [63:0] d;
    cfg_lock = 1'b1;
    msr_wr(IX_BASE, 64'hFEE0_0800, g);
    check("R1 clear ext faults", 64'(g), 1);
    @(negedge clk);
    check("R11 gp single pulse", 64'(gp_fault), 0);
    msr_rd(IX_BASE, d);
    check("R1 base unchanged after ext clear", d, 64'hFEE0_0C00);
    msr_wr(IX_BASE, 64'hFEE0_0400, g);
    check("R1 clear enable faults", 64'(g), 1);
    msr_rd(IX_BASE, d);
    check("R1 base unchanged after en clear", d, 64'hFEE0_0C00);
    msr_wr(IX_BASE, 64'hFEE0_0D00, g);
    check("R2 locked keep-both no fault", 64'(g), 0);
    msr_rd(IX_BASE, d);
    check("R2 locked keep-both accepted", d, 64'hFEE0_0D00);
  endtask

  task automatic t_status_cap;
    logic g; logic [63:0] d;
    msr_rd(IX_STAT, d);
    check("R7 status locked ext", d, 1);
    msr_rd(IX_CAP, d);
    check("R9 cap locked", d, CAPV | (64'd1 << 21));
    msr_wr(IX_STAT, 64'h0, g);
    check("R8 status write faults", 64'(g), 1);
    msr_rd(IX_STAT, d);
    check("R8 status unchanged", d, 1);
  endtask

  task automatic t_mmio_blocked;
    logic [31:0] rd, ma; logic srd, swr, mc; logic [7:0] si;
    cfg_mce_en = 1'b0;
    mm_acc(1'b1, 1'b0, 12'h0B0, rd, srd, swr, si, mc, ma);
    check("R3 blocked read all ones", 64'(rd), 64'hFFFF_FFFF);
    check("R3 no rf read", 64'(srd), 0);
    check("R5 no mc without enable", 64'(mc), 0);
    mm_acc(1'b0, 1'b1, 12'h0B0, rd, srd, swr, si, mc, ma);
    check("R4 no rf write", 64'(swr), 0);
    check("R5 no mc write without enable", 64'(mc), 0);
    cfg_mce_en = 1'b1;
    mm_acc(1'b1, 1'b0, 12'h300, rd, srd, swr, si, mc, ma);
    check("R5 mc on blocked read", 64'(mc), 1);
    check("R5 mc address read", 64'(ma), 64'hFEE0_0300);
    check("R5 mc status", 64'(mc_status), 64'hF);
    mm_acc(1'b0, 1'b1, 12'h3F4, rd, srd, swr, si, mc, ma);
    check("R4 no rf write with mce", 64'(swr), 0);
    check("R5 mc address write", 64'(ma), 64'hFEE0_03F4);
    @(negedge clk);
    check("R11 mc single pulse", 64'(mc_req), 0);
    cfg_mce_en = 1'b0;
  endtask

  task automatic t_lock_not_ext;
    logic g; logic [63:0] d; logic [31:0] rd, ma; logic srd, swr, mc; logic [7:0] si;
    cfg_lock = 1'b0;
    msr_wr(IX_BASE, 64'hFEE0_0800, g);
    check("R2 unlocked leave ext", 64'(g), 0);
    cfg_lock = 1'b1;
    mm_acc(1'b1, 1'b0, 12'h080, rd, srd, swr, si, mc, ma);
    check("R6 locked legacy passes", 64'(rd), 64'hA5A5_A508);
    msr_rd(IX_STAT, d);
    check("R7 status locked legacy", d, 0);
    msr_wr(IX_BASE, 64'hFEE0_0C00, g);
    check("R2 locked ext-clear write accepted", 64'(g), 0);
    msr_rd(IX_STAT, d);
    check("R7 status after lock-in", d, 1);
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlocked();
    t_lock_reject();
    t_status_cap();
    t_mmio_blocked();
    t_lock_not_ext();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule